// File: doc/BRIEF.md
# Break-Before-Make Switch Update Sequencer

This block drives eight switch-control lines and moves them from one pattern to the next without ever letting a path that is being closed overlap a path that is being opened. A new eight-bit target pattern is committed when the frame-select input goes from low to high. The block compares the target with the pattern it is currently driving. It opens every switch that has to turn off, waits a dead time set by a parameter, and then closes every switch that has to turn on. Switches whose state does not change are never touched, so a closed path that stays closed carries no glitch.

When the update opens nothing, the block applies the target at once and does not wait the dead time. If a new commit arrives while a sequence is in its dead time, the word is held in a one-entry slot and applied as soon as the running sequence completes. A later commit replaces an earlier held word. The busy flag covers both the dead time and any held word.

Top module: `bbm_switch_seq`

## Requirements
- R1: While `rst` is high, and on the cycle after it is released, all eight switch outputs are 0 (open) and `busy_o` is 0.
- R2: A commit happens only on a clock edge where `frame_sel_i` is 1 and was 0 at the previous edge. `word_i` is sampled at that edge. A level that is already high when reset is released, or that stays high, causes no commit.
- R3: When a commit opens at least one switch, the edge that samples it drives `sw_o` = old AND new. The new-only bits close exactly `DEAD_CYC` clock cycles later, so no opening and closing ever share a cycle.
- R4: A bit that is 1 in both the old and the new pattern stays 1 on every cycle of the update.
- R5: When a commit opens no switch, `sw_o` takes the new word on the edge that samples it, and `busy_o` stays 0.
- R6: Any pattern is a legal target, including 0x00 and 0xFF. Bit i of `word_i` = 1 closes switch i.
- R7: `busy_o` is 1 from the opening edge until the closing edge. A word committed while busy is applied on the edge after the running sequence closes, and `busy_o` stays 1 until that word has also completed.
- R8: Of several commits made during one busy period, only the last is applied. Earlier held words never appear on `sw_o`.
- R9: With no commit and `busy_o` low, `sw_o` holds its value whatever `word_i` does.
- R10: `DEAD_CYC` counts system clock cycles. A value below 1 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_sel_i | input | 1 | Frame select; a rising level commits `word_i` |
| word_i | input | 8 | New switch pattern, bit i for switch i |
| sw_o | output | 8 | Switch controls, 1 = closed |
| busy_o | output | 1 | Sequence in progress or word held |

## Verification
The bench moves the outputs between patterns that keep some bits, drop some and add some. It samples every cycle of the dead time, so a design that closes too early, skips the opening step, or briefly drops a kept bit shows the wrong pattern in that window. It checks an update that opens nothing, which a design that always waits the dead time would get wrong. It checks the all-off and all-on patterns. It holds the frame select high through reset and again across a changing word, which a level-sensitive design would turn into spurious updates. It issues two commits during one dead time: a design without a held slot loses both words, and one that queues in order briefly shows the stale word.

// File: rtl/bbm_pkg.sv
package bbm_pkg;

    localparam int SW_N = 8;

    typedef logic [SW_N-1:0] sw_word_t;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_DEAD = 1'b1
    } bbm_phase_e;

    typedef struct packed {
        logic     valid;
        sw_word_t word;
    } bbm_req_t;

    // Switches kept closed during the opening step.
    function automatic sw_word_t open_step(sw_word_t cur, sw_word_t tgt);
        return cur & tgt;
    endfunction

    // True when any closed switch must open.
    function automatic logic needs_open(sw_word_t cur, sw_word_t tgt);
        return |(cur & ~tgt);
    endfunction

endpackage

// File: rtl/bbm_commit_queue.sv
module bbm_commit_queue
    import bbm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     frame_sel_i,
    input  sw_word_t word_i,
    input  logic     hold_i,
    input  logic     take_i,
    output bbm_req_t req_o,
    output logic     pend_o
);
    logic     fs_q;
    logic     commit;
    logic     pend_v_q;
    sw_word_t pend_w_q;

    assign commit = frame_sel_i & ~fs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fs_q     <= 1'b1;
            pend_v_q <= 1'b0;
            pend_w_q <= '0;
        end else begin
            fs_q <= frame_sel_i;
            if (commit && hold_i) begin
                pend_v_q <= 1'b1;
                pend_w_q <= word_i;
            end else if (take_i) begin
                pend_v_q <= 1'b0;
            end
        end
    end

    always_comb begin
        req_o.valid = commit | pend_v_q;
        req_o.word  = commit ? word_i : pend_w_q;
    end

    assign pend_o = pend_v_q;

endmodule

// File: rtl/bbm_dead_timer.sv
module bbm_dead_timer #(
    parameter int DEAD_CYC = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic run_i,
    output logic done_o
);
    localparam int EFF_CYC = (DEAD_CYC < 1) ? 1 : DEAD_CYC;
    localparam int CW      = (EFF_CYC < 2) ? 1 : $clog2(EFF_CYC);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (start_i) begin
            cnt_q <= CW'(EFF_CYC - 1);
        end else if (run_i && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done_o = (cnt_q == '0);

endmodule

// File: rtl/bbm_switch_seq.sv
module bbm_switch_seq
    import bbm_pkg::*;
#(
    parameter int DEAD_CYC = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     frame_sel_i,
    input  logic [bbm_pkg::SW_N-1:0] word_i,
    output logic [bbm_pkg::SW_N-1:0] sw_o,
    output logic                     busy_o
);
    bbm_phase_e phase_q;
    sw_word_t   sw_q;
    sw_word_t   tgt_q;
    bbm_req_t   req;
    logic       pend;
    logic       take;
    logic       start_dead;
    logic       dead_done;

    assign take       = (phase_q == PH_IDLE) && req.valid;
    assign start_dead = take && needs_open(sw_q, req.word);

    bbm_commit_queue u_queue (
        .clk         (clk),
        .rst         (rst),
        .frame_sel_i (frame_sel_i),
        .word_i      (word_i),
        .hold_i      (phase_q == PH_DEAD),
        .take_i      (take),
        .req_o       (req),
        .pend_o      (pend)
    );

    bbm_dead_timer #(.DEAD_CYC(DEAD_CYC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_dead),
        .run_i   (phase_q == PH_DEAD),
        .done_o  (dead_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            sw_q    <= '0;
            tgt_q   <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    if (take) begin
                        tgt_q <= req.word;
                        if (start_dead) begin
                            sw_q    <= open_step(sw_q, req.word);
                            phase_q <= PH_DEAD;
                        end else begin
                            sw_q <= req.word;
                        end
                    end
                end
                PH_DEAD: begin
                    if (dead_done) begin
                        sw_q    <= tgt_q;
                        phase_q <= PH_IDLE;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign sw_o   = sw_q;
    assign busy_o = (phase_q == PH_DEAD) || pend;

endmodule

// File: rtl/bbm_switch_seq_chk.sv
module bbm_switch_seq_chk #(
    parameter int DEAD_CYC = 3
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     frame_sel_i,
    input logic [bbm_pkg::SW_N-1:0] sw_o,
    input logic                     busy_o
);
    localparam int EFF = (DEAD_CYC < 1) ? 1 : DEAD_CYC;
    localparam int GW  = $clog2(EFF + 1);

    logic                     live;
    logic                     fs_q;
    logic                     quiet_q;
    logic [bbm_pkg::SW_N-1:0] sw_prev;
    logic [GW-1:0]            gap;
    logic                     fell;
    logic                     rose;

    assign fell = |(sw_prev & ~sw_o);
    assign rose = |(~sw_prev & sw_o);

    always_ff @(posedge clk) begin
        if (rst) begin
            live    <= 1'b0;
            fs_q    <= 1'b1;
            quiet_q <= 1'b0;
            sw_prev <= '0;
            gap     <= GW'(EFF);
        end else begin
            live    <= 1'b1;
            fs_q    <= frame_sel_i;
            quiet_q <= !busy_o && !(frame_sel_i && !fs_q);
            sw_prev <= sw_o;
            if (fell)
                gap <= GW'(1);
            else if (gap < GW'(EFF))
                gap <= gap + 1'b1;
        end
    end

    // R1: outputs cleared by reset
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (sw_o == '0 && !busy_o));

    // R3: no closing in the same cycle as an opening
    a_r3_no_overlap: assert property (@(posedge clk) disable iff (rst)
        (live && rose) |-> !fell);

    // R3: closings wait the dead time after the last opening
    a_r3_dead_gap: assert property (@(posedge clk) disable iff (rst)
        (live && rose) |-> (gap >= GW'(EFF)));

    // R7: busy is raised whenever switches open
    a_r7_busy_on_open: assert property (@(posedge clk) disable iff (rst)
        (live && fell) |-> busy_o);

    // R9: outputs hold without commit or busy
    a_r9_quiet_hold: assert property (@(posedge clk) disable iff (rst)
        (live && quiet_q) |-> (sw_o == sw_prev));

endmodule

bind bbm_switch_seq bbm_switch_seq_chk #(.DEAD_CYC(DEAD_CYC)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .frame_sel_i (frame_sel_i),
    .sw_o        (sw_o),
    .busy_o      (busy_o)
);

// File: tb/sim_bbm_switch_seq.sv
module sim_bbm_switch_seq;
    localparam int DEAD = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fs  = 1'b1;
    logic [7:0] word = 8'hFF;
    logic [7:0] sw;
    logic       busy;
    logic [7:0] mdl = 8'h00;
    int         checks = 0;
    int         errors = 0;

    always #2 clk = ~clk;

    bbm_switch_seq #(.DEAD_CYC(DEAD)) u0 (
        .clk         (clk),
        .rst         (rst),
        .frame_sel_i (fs),
        .word_i      (word),
        .sw_o        (sw),
        .busy_o      (busy)
    );

    task automatic chk(input string req, input logic [7:0] exp_sw, input logic exp_busy);
        checks++;
        if (sw !== exp_sw || busy !== exp_busy) begin
            errors++;
            $display("FAIL %s: sw=%h busy=%b expected sw=%h busy=%b",
                     req, sw, busy, exp_sw, exp_busy);
        end
    endtask

    // One full update from the model state; frame select must be low on entry.
    task automatic do_update(input logic [7:0] nw, input string req);
        logic [7:0] keep;
        keep = mdl & nw;
        @(negedge clk); word = nw; fs = 1'b1;
        @(negedge clk); fs = 1'b0;
        if ((mdl & ~nw) != 8'h00) begin
            chk({req, " open step"}, keep, 1'b1);
            for (int i = 1; i < DEAD; i++) begin
                @(negedge clk);
                chk({req, " dead window"}, keep, 1'b1);
            end
            @(negedge clk);
            chk({req, " closed"}, nw, 1'b0);
        end else begin
            chk({req, " direct"}, nw, 1'b0);
        end
        mdl = nw;
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk("R1 in reset", 8'h00, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after release", 8'h00, 1'b0);
        repeat (3) @(negedge clk);
        chk("R2 high level at release ignored", 8'h00, 1'b0);
        fs = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_level_hold;
        @(negedge clk); word = 8'h0F; fs = 1'b1;
        @(negedge clk);
        chk("R2 commit on rise", 8'h0F, 1'b0);
        word = 8'hF0;
        repeat (3) @(negedge clk);
        chk("R2 held high no recommit", 8'h0F, 1'b0);
        fs = 1'b0;
        word = 8'h77;
        repeat (3) @(negedge clk);
        chk("R9 word change ignored", 8'h0F, 1'b0);
        mdl = 8'h0F;
    endtask

    task automatic t_pending;
        // from 0xF0: commit 0x0F, then 0x33 and 0xCC during dead time
        @(negedge clk); word = 8'h0F; fs = 1'b1;
        @(negedge clk); fs = 1'b0; word = 8'h33;
        chk("R7 first open", 8'h00, 1'b1);
        @(negedge clk); fs = 1'b1;
        chk("R7 dead", 8'h00, 1'b1);
        @(negedge clk); fs = 1'b0; word = 8'hCC;
        chk("R7 dead", 8'h00, 1'b1);
        @(negedge clk); fs = 1'b1;
        chk("R7 dead", 8'h00, 1'b1);
        @(negedge clk); fs = 1'b0;
        chk("R7 first closed, busy held", 8'h0F, 1'b1);
        @(negedge clk);
        chk("R8 latest word opens", 8'h0C, 1'b1);
        for (int i = 1; i < DEAD; i++) begin
            @(negedge clk);
            chk("R8 second dead window", 8'h0C, 1'b1);
        end
        @(negedge clk);
        chk("R8 latest word applied", 8'hCC, 1'b0);
        mdl = 8'hCC;
    endtask

    initial begin
        t_reset();
        do_update(8'hA5, "R5 R6 no-open update");
        do_update(8'h3C, "R3 R4 mixed update");
        do_update(8'hFF, "R5 to all-on");
        do_update(8'h00, "R6 R3 to all-off");
        do_update(8'h00, "R5 same word");
        t_level_hold();
        do_update(8'hF0, "R3 R10 swap");
        t_pending();
        do_update(8'hC3, "R4 keep upper/lower");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule